// File: doc/BRIEF.md
# Dual-Stage Selectable Register Pipeline with Test Observation

This block carries a 32-bit word through two register stages. Before the first stage, a bank of 2:1 selectors picks, bit by bit, between two input words, and one shared control line steers every selector. The second stage drives a true output bus and an inverted output bus.

Three test aids sit beside the datapath. Two 16-to-1 observation selectors look into the first input word. Both use one 4-bit index and each has its own enable. An XOR tree folds every data and control input into a single parity bit for parametric test. A 6-bit bus runs straight from input to output with no logic. A single asynchronous master reset clears every flip-flop.

Top module: `dualstage_mux_pipe`

## Requirements
- R1: When `pickB` is 0 at a rising clock edge, the first stage captures `wordA`. When `pickB` is 1, it captures `wordB`. One select line serves all 32 bits.
- R2: A word captured by the first stage at clock edge n appears on `qTrue` right after edge n+1. The latency is two edges from input to output.
- R3: While `rstHi` (active high, asynchronous) is 1, both stages hold zero, so `qTrue` is all zeros and `qInv` is all ones. This takes effect without waiting for a clock edge.
- R4: `qInv` is always the bitwise inverse of `qTrue`.
- R5: When `obsEnLo` is 1, `obsLo` equals `wordA[obsIdx]`. When `obsEnHi` is 1, `obsHi` equals `wordA[16 + obsIdx]`. Both are combinational, and `obsIdx` is an unsigned 4-bit index.
- R6: When an observation enable is 0, its output is 0 whatever the data and the index.
- R7: `parityOut` is the combinational XOR of every bit of `wordA`, `wordB`, `pickB`, `obsIdx`, `obsEnLo`, `obsEnHi`, `rstHi` and `passIn`. The clock is not included.
- R8: `passOut` equals `passIn` at all times, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rstHi | input | 1 | Asynchronous master reset, active high |
| wordA | input | 32 | First data word, also observed by the test selectors |
| wordB | input | 32 | Second data word |
| pickB | input | 1 | Shared selector control: 1 picks `wordB` |
| obsIdx | input | 4 | Bit index shared by both observation selectors |
| obsEnLo | input | 1 | Enable for the observation output over `wordA[15:0]` |
| obsEnHi | input | 1 | Enable for the observation output over `wordA[31:16]` |
| passIn | input | 6 | Pass-through bus input |
| qTrue | output | 32 | Second-stage register contents |
| qInv | output | 32 | Bitwise inverse of `qTrue` |
| obsLo | output | 1 | Observed bit of the lower half of `wordA` |
| obsHi | output | 1 | Observed bit of the upper half of `wordA` |
| parityOut | output | 1 | XOR of all data and control inputs |
| passOut | output | 6 | Copy of `passIn` |

## Verification
The clocked assertions assume that `wordA`, `wordB` and `pickB` are stable around each rising edge. They also assume that reset is only raised or dropped away from an edge, so that the sampled values match what the flip-flops captured. The bench drives every input just after the falling edge and moves reset only at points between edges. This keeps the stimulus inside those assumptions. The latency and capture checks wait until enough edges have passed since reset release, so they never compare against values from before the reset.

// File: rtl/mrp_pkg.sv
package mrp_pkg;
  localparam int DATA_W    = 32;
  localparam int OBS_SEL_W = 4;
  localparam int LANE_W    = 1 << OBS_SEL_W;
  localparam int LANES     = DATA_W / LANE_W;
  localparam int PASS_W    = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic                 pickB;
    logic [OBS_SEL_W-1:0] obsIdx;
    logic [LANES-1:0]     obsEn;
  } strobe_t;
endpackage

// File: rtl/mrp_ctrl.sv
module mrp_ctrl
  import mrp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = OBS_SEL_W,
  parameter int PW = PASS_W
) (
  input  logic          rstHi,
  input  logic [DW-1:0] wordA,
  input  logic [DW-1:0] wordB,
  input  logic          pickB,
  input  logic [SW-1:0] obsIdx,
  input  logic          obsEnLo,
  input  logic          obsEnHi,
  input  logic [PW-1:0] passIn,
  output strobe_t       strb,
  output logic          parityOut
);
  localparam int TREE_W = 2 * DW + SW + PW + 4;

  logic [TREE_W-1:0] treeIn;

  always_comb begin
    strb.pickB  = pickB;
    strb.obsIdx = obsIdx;
    strb.obsEn  = {obsEnHi, obsEnLo};
  end

  // parametric-test tree, no registers
  assign treeIn    = {wordA, wordB, pickB, obsIdx, obsEnLo, obsEnHi, rstHi, passIn};
  assign parityOut = ^treeIn;
endmodule

// File: rtl/mrp_datapath.sv
module mrp_datapath
  import mrp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int LW = LANE_W,
  parameter int NL = LANES
) (
  input  logic          clk,
  input  logic          rstHi,
  input  logic [DW-1:0] wordA,
  input  logic [DW-1:0] wordB,
  input  strobe_t       strb,
  output logic [DW-1:0] qTrue,
  output logic [DW-1:0] qInv,
  output logic [NL-1:0] obsOut
);
  logic [DW-1:0] selWord;
  logic [DW-1:0] stage1;
  logic [DW-1:0] stage2;

  for (genvar i = 0; i < DW; i++) begin : gSel
    assign selWord[i] = strb.pickB ? wordB[i] : wordA[i];
  end

  always_ff @(posedge clk or posedge rstHi) begin
    if (rstHi) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= selWord;
      stage2 <= stage1;
    end
  end

  assign qTrue = stage2;
  assign qInv  = ~stage2;

  for (genvar g = 0; g < NL; g++) begin : gObs
    logic [LW-1:0] laneBits;
    assign laneBits  = wordA[g*LW +: LW];
    assign obsOut[g] = strb.obsEn[g] & laneBits[strb.obsIdx];

    assert_obs_on_R5: assert property (@(posedge clk) disable iff (rstHi)
      strb.obsEn[g] |-> obsOut[g] == wordA[g*LW + int'(strb.obsIdx)]);
    assert_obs_off_R6: assert property (@(posedge clk) disable iff (rstHi)
      !strb.obsEn[g] |-> !obsOut[g]);
  end

  // edges seen since reset release, saturating at 2
  logic [1:0] sinceRst;
  always_ff @(posedge clk or posedge rstHi) begin
    if (rstHi) sinceRst <= '0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  assert_take_a_R1: assert property (@(posedge clk) disable iff (rstHi)
    (sinceRst != 2'd0 && !$past(strb.pickB)) |-> stage1 == $past(wordA));
  assert_take_b_R1: assert property (@(posedge clk) disable iff (rstHi)
    (sinceRst != 2'd0 && $past(strb.pickB)) |-> stage1 == $past(wordB));
  assert_latency_R2: assert property (@(posedge clk) disable iff (rstHi)
    (sinceRst == 2'd2) |-> qTrue == $past(selWord, 2));
  assert_clear_R3: assert property (@(posedge clk)
    rstHi |-> (qTrue == '0 && qInv == '1));
endmodule

// File: rtl/dualstage_mux_pipe.sv
module dualstage_mux_pipe
  import mrp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = OBS_SEL_W,
  parameter int PW = PASS_W
) (
  input  logic          clk,
  input  logic          rstHi,
  input  logic [DW-1:0] wordA,
  input  logic [DW-1:0] wordB,
  input  logic          pickB,
  input  logic [SW-1:0] obsIdx,
  input  logic          obsEnLo,
  input  logic          obsEnHi,
  input  logic [PW-1:0] passIn,
  output logic [DW-1:0] qTrue,
  output logic [DW-1:0] qInv,
  output logic          obsLo,
  output logic          obsHi,
  output logic          parityOut,
  output logic [PW-1:0] passOut
);
  localparam int NL = DW / (1 << SW);

  strobe_t       strb;
  logic [NL-1:0] obsOut;

  mrp_ctrl #(.DW(DW), .SW(SW), .PW(PW)) uCtrl (
    .rstHi(rstHi), .wordA(wordA), .wordB(wordB), .pickB(pickB),
    .obsIdx(obsIdx), .obsEnLo(obsEnLo), .obsEnHi(obsEnHi),
    .passIn(passIn), .strb(strb), .parityOut(parityOut)
  );

  mrp_datapath #(.DW(DW), .LW(1 << SW), .NL(NL)) uData (
    .clk(clk), .rstHi(rstHi), .wordA(wordA), .wordB(wordB),
    .strb(strb), .qTrue(qTrue), .qInv(qInv), .obsOut(obsOut)
  );

  assign obsLo   = obsOut[0];
  assign obsHi   = obsOut[NL-1];
  assign passOut = passIn;
endmodule

// File: tb/sim_dualstage_mux_pipe.sv
module sim_dualstage_mux_pipe;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstHi = 1'b0;
  logic [31:0] wordA = '0, wordB = '0;
  logic        pickB = 1'b0;
  logic [3:0]  obsIdx = '0;
  logic        obsEnLo = 1'b0, obsEnHi = 1'b0;
  logic [5:0]  passIn = '0;
  logic [31:0] qTrue, qInv;
  logic        obsLo, obsHi, parityOut;
  logic [5:0]  passOut;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] expS1 = '0, expS2 = '0;

  dualstage_mux_pipe u0 (
    .clk(clk), .rstHi(rstHi), .wordA(wordA), .wordB(wordB), .pickB(pickB),
    .obsIdx(obsIdx), .obsEnLo(obsEnLo), .obsEnHi(obsEnHi), .passIn(passIn),
    .qTrue(qTrue), .qInv(qInv), .obsLo(obsLo), .obsHi(obsHi),
    .parityOut(parityOut), .passOut(passOut)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic obsModel(logic [31:0] a, logic [3:0] idx, logic en, int lane);
    int pos;
    pos = lane * 16 + int'(idx);
    return en ? a[pos] : 1'b0;
  endfunction

  function automatic logic parModel();
    logic p;
    p = pickB ^ obsEnLo ^ obsEnHi ^ rstHi;
    for (int k = 0; k < 32; k++) p = p ^ wordA[k] ^ wordB[k];
    for (int k = 0; k < 4; k++) p = p ^ obsIdx[k];
    for (int k = 0; k < 6; k++) p = p ^ passIn[k];
    return p;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkRegs();
    chk("R2 qTrue", qTrue, expS2);
    chk("R4 qInv", qInv, ~expS2);
  endtask

  task automatic checkComb();
    chk("R5/R6 obsLo", {31'd0, obsLo}, {31'd0, obsModel(wordA, obsIdx, obsEnLo, 0)});
    chk("R5/R6 obsHi", {31'd0, obsHi}, {31'd0, obsModel(wordA, obsIdx, obsEnHi, 1)});
    chk("R7 parity", {31'd0, parityOut}, {31'd0, parModel()});
    chk("R8 passOut", {26'd0, passOut}, {26'd0, passIn});
  endtask

  // one clock: model update at the edge, register check at the falling edge
  task automatic step();
    @(posedge clk);
    if (!rstHi) begin
      expS2 = expS1;
      expS1 = pickB ? wordB : wordA; // R1
    end
    @(negedge clk);
    checkRegs();
  endtask

  task automatic drive(logic [31:0] a, logic [31:0] b, logic p, logic [3:0] i,
                       logic el, logic eh, logic [5:0] ps);
    wordA = a; wordB = b; pickB = p; obsIdx = i;
    obsEnLo = el; obsEnHi = eh; passIn = ps;
    #1;
    checkComb();
  endtask

  task automatic randDrive();
    drive($urandom, $urandom, 1'($urandom), 4'($urandom),
          1'($urandom), 1'($urandom), 6'($urandom));
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1 rstHi = 1'b1;
    #1;
    chk("R3 reset qTrue", qTrue, 32'h0);
    chk("R3 reset qInv", qInv, 32'hFFFF_FFFF);
    step();
    chk("R3 held in reset", qTrue, 32'h0);
    rstHi = 1'b0;
    #1 checkComb();

    // directed R1: select A then B, watch the two-edge latency
    drive(32'hA5A5_0001, 32'h5A5A_0002, 1'b0, 4'd0, 1'b1, 1'b1, 6'h15);
    step();
    chk("R2 not yet out", qTrue, 32'h0);
    drive(32'h1111_2222, 32'hCAFE_F00D, 1'b1, 4'd15, 1'b1, 1'b1, 6'h2A);
    step();
    chk("R1 A picked", qTrue, 32'hA5A5_0001);
    drive(32'h0, 32'h0, 1'b0, 4'd7, 1'b0, 1'b0, 6'h0);
    step();
    chk("R1 B picked", qTrue, 32'hCAFE_F00D);

    // R6: enables low with all-ones data
    drive(32'hFFFF_FFFF, 32'h0, 1'b0, 4'd3, 1'b0, 1'b0, 6'h3F);
    chk("R6 obsLo off", {31'd0, obsLo}, 32'd0);
    chk("R6 obsHi off", {31'd0, obsHi}, 32'd0);
    // R5: single-bit sweeps over each index
    for (int i = 0; i < 16; i++) begin
      drive(32'h1 << i, 32'h1 << (16 + i), 1'b0, 4'(i), 1'b1, 1'b1, 6'h0);
      chk("R5 lo lane hit", {31'd0, obsLo}, 32'd1);
      drive(32'h1 << (16 + i), 32'h0, 1'b1, 4'(i), 1'b1, 1'b1, 6'h0);
      chk("R5 hi lane hit", {31'd0, obsHi}, 32'd1);
      step();
    end
    // R7: all-zero inputs give even parity
    drive(32'h0, 32'h0, 1'b0, 4'd0, 1'b0, 1'b0, 6'h0);
    chk("R7 zero parity", {31'd0, parityOut}, 32'd0);

    for (int n = 0; n < 400; n++) begin
      randDrive();
      step();
      if (n == 200) begin
        #2 rstHi = 1'b1;
        #1;
        expS1 = '0; expS2 = '0;
        chk("R3 async clear", qTrue, 32'h0);
        chk("R3 async inv", qInv, 32'hFFFF_FFFF);
        checkComb();
        step();
        @(negedge clk);
        rstHi = 1'b0;
        #1 checkComb();
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule